// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a calendar clock that occupies the top eight byte addresses of an 8K-byte space. The addresses below those eight belong to ordinary RAM. For those addresses the block only raises a select for the RAM array. It keeps two copies of the time. The first is a set of internal BCD counters, advanced by a one-pulse-per-second tick. The second is a visible register set that the bytewide bus reads and writes.

Software sets a halt bit before it reads the time. This freezes the visible copy, so a multi-byte read stays consistent, and the internal counters keep running underneath. When the halt bit is cleared, the visible set is refreshed in one step. The refresh happens only after the bit has stayed low for a set number of clock cycles.

Bus writes to the time fields land in the visible copy at once. They are loaded into the internal counters at the next tick. A power-fail input shuts out all bus traffic.

Top module: `rtc_calendar_regs`

## Requirements
- R1: With `bus_sel` high and power good, an address below 0x1FF8 asserts `ram_sel` and leaves every clock register unchanged. A read there returns 0 on `rdata`. Addresses 0x1FF8 to 0x1FFF select the clock registers and never assert `ram_sel`.
- R2: The register offsets (address minus 0x1FF8) are as follows:
  - 0: control. Bit 6 is halt, bits 5:0 are the BCD century, bit 7 reads 0.
  - 1: seconds (bits 6:0).
  - 2: minutes (bits 6:0).
  - 3: hours (bits 5:0).
  - 4: day of week (bits 2:0).
  - 5: date (bits 5:0).
  - 6: month (bits 4:0).
  - 7: year (bits 7:0).
  
  Bits outside these fields are dropped on write and read as 0.
- R3: Seconds and minutes roll from 59 to 00 and hours from 23 to 00, all in BCD and 24-hour form, each carrying into the next field.
- R4: Day of week advances with each date change and wraps from 7 to 1.
- R5: The date wraps to 01 after day 30 of April, June, September and November, and after day 31 of the other months except February. The month then advances, and wraps from 12 to 01.
- R6: In a year whose two-digit value is divisible by 4 (00 included), February ends after day 29. In any other year it ends after day 28.
- R7: The year wraps from 99 to 00 and the century increments.
- R8: While halt is 1, the visible registers hold the values from the moment halt was set, and the internal counters keep counting.
- R9: After halt is written 0, the visible set is not refreshed within the first SETTLE_CYCLES-1 cycles. After that it is loaded from the internal counters in a single step.
- R10: A write to a time field reads back at once. It is copied into the internal counter on the next tick, which then does not advance the time. A control write that leaves the century unchanged only changes the halt bit.
- R11: While `pwr_fail` is high, no write takes effect, `rdata` is 0 and `ram_sel` stays low.
- R12: After reset the registers read as follows: century 20, year 00, month 01, date 01, day 1, and 00:00:00, with halt clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Supply out of tolerance; blocks the bus |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the visible registers |
| ram_sel | output | 1 | Access belongs to the RAM array below the clock |

## Verification
The bench builds the block with SETTLE_CYCLES set to 16 instead of the default 25000. This puts the edges of the refresh delay a few cycles apart, where the bench can probe them. ADDR_W stays at 13, so the real 8K decode is exercised. Ticks are driven by the bench rather than timed. This makes it cheap to cross minute, day, month, year and century boundaries, including February in leap and common years.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NREG = 8;
  localparam int OFS_W = $clog2(NREG);

  // Byte order matches the bus offset: byte k sits at bits [8k+7:8k]
  typedef struct packed {
    logic [7:0] year;     // 7
    logic [7:0] month;    // 6
    logic [7:0] date;     // 5
    logic [7:0] day;      // 4
    logic [7:0] hour;     // 3
    logic [7:0] minute;   // 2
    logic [7:0] second;   // 1
    logic [7:0] century;  // 0
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{
    year: 8'h00, month: 8'h01, date: 8'h01, day: 8'h01,
    hour: 8'h00, minute: 8'h00, second: 8'h00, century: 8'h20};

  function automatic logic [7:0] field_mask(input logic [OFS_W-1:0] ofs);
    case (ofs)
      3'd0: field_mask = 8'h3F;
      3'd1: field_mask = 8'h7F;
      3'd2: field_mask = 8'h7F;
      3'd3: field_mask = 8'h3F;
      3'd4: field_mask = 8'h07;
      3'd5: field_mask = 8'h3F;
      3'd6: field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: month_len = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default: month_len = 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.second < 8'h59) n.second = bcd_inc(t.second);
    else begin
      n.second = 8'h00;
      if (t.minute < 8'h59) n.minute = bcd_inc(t.minute);
      else begin
        n.minute = 8'h00;
        if (t.hour < 8'h23) n.hour = bcd_inc(t.hour);
        else begin
          n.hour = 8'h00;
          n.day  = (t.day >= 8'h07) ? 8'h01 : bcd_inc(t.day);
          if (t.date < month_len(t.month, t.year)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.month < 8'h12) n.month = bcd_inc(t.month);
            else begin
              n.month = 8'h01;
              if (t.year < 8'h99) n.year = bcd_inc(t.year);
              else begin
                n.year    = 8'h00;
                n.century = (t.century >= 8'h39) ? 8'h00 : bcd_inc(t.century);
              end
            end
          end
        end
      end
    end
    advance = n;
  endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              ram_sel,
  output logic [OFS_W-1:0]  ofs
);

  logic go;
  logic hit;

  assign go      = bus_sel && !pwr_fail;
  assign hit     = &addr[ADDR_W-1:OFS_W];
  assign ofs     = addr[OFS_W-1:0];
  assign reg_wr  = go && hit && bus_wr;
  assign reg_rd  = go && hit && !bus_wr;
  assign ram_sel = go && !hit;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && (reg_wr || reg_rd))); // R1

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NREG-1:0] load_mask,
  input  rtc_time_t       load_val,
  output rtc_time_t       cur
);

  rtc_time_t cur_q;
  rtc_time_t stepped;
  logic [NREG*8-1:0] merged;
  logic [NREG*8-1:0] cur_flat;
  logic [NREG*8-1:0] load_flat;
  logic any_load;

  assign cur_flat  = cur_q;
  assign load_flat = load_val;
  assign any_load  = |load_mask;
  assign stepped   = advance(cur_q);

  for (genvar g = 0; g < NREG; g++) begin : g_merge
    assign merged[8*g +: 8] = load_mask[g] ? load_flat[8*g +: 8] : cur_flat[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= RESET_TIME;
    else if (tick) begin
      if (any_load) cur_q <= rtc_time_t'(merged);
      else          cur_q <= stepped;
    end
  end

  assign cur = cur_q;

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_load) |=> (cur_q.second != $past(cur_q.second))); // R3

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load_mask[1]) |=> (cur_q.second == $past(load_val.second))); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_q)); // R8

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_data,
  input  rtc_time_t        int_time,
  output rtc_time_t        vis,
  output logic             halt,
  output logic [NREG-1:0]  pend_mask,
  output logic             xfer_ok
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [NREG*8-1:0] vis_q;
  logic              halt_q;
  logic [CNT_W-1:0]  low_cnt_q;
  logic [NREG-1:0]   pend_q;
  logic              settled;
  logic              cen_change;

  assign settled    = (low_cnt_q == CNT_MAX);
  assign xfer_ok    = !halt_q && settled && (pend_q == '0);
  assign cen_change = (wr_data[5:0] != vis_q[5:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q     <= RESET_TIME;
      halt_q    <= 1'b0;
      low_cnt_q <= CNT_MAX;
      pend_q    <= '0;
    end else begin
      if (halt_q)        low_cnt_q <= '0;
      else if (!settled) low_cnt_q <= low_cnt_q + 1'b1;
      if (tick)    pend_q <= '0;
      if (xfer_ok) vis_q  <= int_time;
      if (wr_en) begin
        if (wr_ofs == '0) begin
          halt_q     <= wr_data[6];
          vis_q[7:0] <= {2'b00, wr_data[5:0]};
          if (cen_change) pend_q[0] <= 1'b1;
        end else begin
          vis_q[8*wr_ofs +: 8] <= wr_data & field_mask(wr_ofs);
          pend_q[wr_ofs]       <= 1'b1;
        end
      end
    end
  end

  assign vis       = rtc_time_t'(vis_q);
  assign halt      = halt_q;
  assign pend_mask = pend_q;

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> $stable(vis_q)); // R8

  AST_VIS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vis_q) |-> ($past(wr_en) || $past(xfer_ok))); // R9

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (pend_q == '0)); // R10

  AST_NO_XFER_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_q) |-> !xfer_ok); // R9

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int SETTLE_CYCLES = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              pwr_fail,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ram_sel
);

  logic              reg_wr;
  logic              reg_rd;
  logic [OFS_W-1:0]  ofs;
  rtc_time_t         int_time;
  rtc_time_t         vis;
  logic              halt;
  logic [NREG-1:0]   pend_mask;
  logic              xfer_ok;
  logic [NREG*8-1:0] vis_flat;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .addr(addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .ram_sel(ram_sel), .ofs(ofs));

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load_mask(pend_mask),
    .load_val(vis), .cur(int_time));

  rtc_shadow #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_shd (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(reg_wr), .wr_ofs(ofs),
    .wr_data(wdata), .int_time(int_time), .vis(vis), .halt(halt),
    .pend_mask(pend_mask), .xfer_ok(xfer_ok));

  assign vis_flat = vis;

  always_comb begin
    rdata = 8'h00;
    if (reg_rd) begin
      if (ofs == '0) rdata = {1'b0, halt, vis_flat[5:0]};
      else           rdata = vis_flat[8*ofs +: 8];
    end
  end

  AST_PF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (rdata == 8'h00 && !ram_sel)); // R11

  AST_PF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && !tick_1hz && halt) |=> $stable(vis)); // R11

endmodule

// File: tb/rtc_calendar_regs_tb.sv
module rtc_calendar_regs_tb;

  localparam int ADDR_W = 13;
  localparam int SETTLE = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_1hz = 1'b0;
  logic              pwr_fail = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              ram_sel;

  int n_chk = 0;
  int n_err = 0;
  int m[8];   // model, index = offset: 0 cen,1 sec,2 min,3 hr,4 dow,5 date,6 mon,7 yr
  int s[8];   // snapshot
  bit m_halt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_regs #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ram_sel(ram_sel));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_of(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m[1]++;
    if (m[1] < 60) return;
    m[1] = 0; m[2]++;
    if (m[2] < 60) return;
    m[2] = 0; m[3]++;
    if (m[3] < 24) return;
    m[3] = 0;
    m[4] = (m[4] == 7) ? 1 : m[4] + 1;
    m[5]++;
    if (m[5] <= days_of(m[6], m[7])) return;
    m[5] = 1; m[6]++;
    if (m[6] <= 12) return;
    m[6] = 1; m[7]++;
    if (m[7] < 100) return;
    m[7] = 0;
    m[0] = (m[0] == 39) ? 0 : m[0] + 1;
  endtask

  function automatic logic [7:0] exp_byte(input int v, input int ofs, input bit h);
    if (ofs == 0) return {1'b0, h, bcd(v)[5:0]};
    return bcd(v);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int ofs, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; addr = {10'h3FF, 3'(ofs)}; wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int ofs, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; addr = {10'h3FF, 3'(ofs)};
    #1 d = rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_model(input string req);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      bus_read(k, d);
      chk(req, $sformatf("reg%0d", k), d, exp_byte(m[k], k, m_halt));
    end
  endtask

  task automatic check_snap(input string req);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      bus_read(k, d);
      chk(req, $sformatf("frozen reg%0d", k), d, exp_byte(s[k], k, 1'b1));
    end
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int dw, input int h, input int mi, input int sc);
    bus_write(0, 8'h40 | bcd(c));
    bus_write(1, bcd(sc)); bus_write(2, bcd(mi)); bus_write(3, bcd(h));
    bus_write(4, bcd(dw)); bus_write(5, bcd(dt)); bus_write(6, bcd(mo));
    bus_write(7, bcd(y));
    pulse_tick();
    bus_write(0, bcd(c));
    idle(SETTLE + 3);
    m[0] = c; m[1] = sc; m[2] = mi; m[3] = h; m[4] = dw; m[5] = dt; m[6] = mo; m[7] = y;
    m_halt = 0;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      pulse_tick();
      idle(2);
      model_step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R12 reset contents
    m = '{20, 0, 0, 0, 1, 1, 1, 0};
    check_model("R12");

    // R2 field masks
    bus_write(4, 8'hF5); bus_read(4, d); chk("R2", "day mask", d, 8'h05);
    bus_write(3, 8'hE3); bus_read(3, d); chk("R2", "hour mask", d, 8'h23);
    bus_write(6, 8'hF2); bus_read(6, d); chk("R2", "month mask", d, 8'h12);
    bus_write(1, 8'hD9); bus_read(1, d); chk("R2", "second mask", d, 8'h59);

    // R3 time rollover
    set_time(20, 23, 6, 15, 3, 23, 59, 58);
    check_model("R3");
    run_ticks(1); check_model("R3");
    run_ticks(1); check_model("R3");

    // R4 day of week wrap
    set_time(20, 23, 6, 17, 7, 23, 59, 59);
    run_ticks(1); check_model("R4");

    // R5 month lengths
    set_time(20, 23, 4, 30, 2, 23, 59, 59);
    run_ticks(1); check_model("R5");
    set_time(20, 23, 1, 31, 2, 23, 59, 59);
    run_ticks(1); check_model("R5");
    set_time(20, 23, 12, 31, 2, 23, 59, 59);
    run_ticks(1); check_model("R5");

    // R6 leap handling
    set_time(20, 24, 2, 28, 3, 23, 59, 59);
    run_ticks(1); check_model("R6");
    set_time(20, 24, 2, 29, 4, 23, 59, 59);
    run_ticks(1); check_model("R6");
    set_time(20, 23, 2, 28, 2, 23, 59, 59);
    run_ticks(1); check_model("R6");
    set_time(20, 0, 2, 28, 2, 23, 59, 59);
    run_ticks(1); check_model("R6");

    // R7 century carry
    set_time(19, 99, 12, 31, 5, 23, 59, 59);
    run_ticks(1); check_model("R7");

    // R8 halt freezes visible copy; R9 delayed refresh
    set_time(20, 25, 3, 10, 1, 8, 30, 10);
    bus_write(0, 8'h40 | bcd(20));
    idle(2);
    s = m;
    run_ticks(3);
    check_snap("R8");
    bus_write(0, bcd(20));
    idle(SETTLE - 4);
    bus_read(1, d);
    chk("R9", "no early refresh", d, bcd(s[1]));
    idle(8);
    m_halt = 0;
    check_model("R9");

    // R10 write then load on tick
    bus_write(1, 8'h30);
    bus_read(1, d); chk("R10", "immediate readback", d, 8'h30);
    pulse_tick(); idle(2);
    m[1] = 30;
    check_model("R10");
    run_ticks(1); check_model("R10");
    bus_write(0, bcd(m[0]));
    run_ticks(1); check_model("R10");

    // R11 power fail
    pwr_fail = 1'b1;
    bus_write(1, 8'h45);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; addr = {10'h3FF, 3'd1};
    #1 chk("R11", "rdata blocked", rdata, 8'h00);
    addr = 13'h0040;
    #0.5 chk("R11", "ram_sel blocked", {7'b0, ram_sel}, 8'h00);
    bus_sel = 1'b0;
    pwr_fail = 1'b0;
    idle(2);
    check_model("R11");

    // R1 RAM region decode
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; addr = 13'h1FF7; wdata = 8'h11;
    #1 chk("R1", "ram_sel on write", {7'b0, ram_sel}, 8'h01);
    @(negedge clk);
    bus_wr = 1'b0; addr = 13'h0123;
    #1 chk("R1", "rdata on ram read", rdata, 8'h00);
    addr = 13'h1FF8;
    #0.5 chk("R1", "no ram_sel on clock", {7'b0, ram_sel}, 8'h00);
    bus_sel = 1'b0;
    check_model("R1");

    // Random dates, biased toward rollovers
    for (int it = 0; it < 24; it++) begin
      int c, y, mo, dt, dw, h, mi, sc, nt;
      c  = 19 + int'($urandom_range(0, 1));
      y  = int'($urandom_range(0, 99));
      mo = int'($urandom_range(1, 12));
      dt = ($urandom_range(0, 1) == 1) ? days_of(mo, y) : int'($urandom_range(1, days_of(mo, y)));
      dw = int'($urandom_range(1, 7));
      h  = ($urandom_range(0, 2) != 0) ? 23 : int'($urandom_range(0, 23));
      mi = ($urandom_range(0, 2) != 0) ? 59 : int'($urandom_range(0, 59));
      sc = int'($urandom_range(55, 59));
      nt = int'($urandom_range(1, 6));
      set_time(c, y, mo, dt, dw, h, mi, sc);
      run_ticks(nt);
      check_model((mo == 2) ? "R6" : "R5");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule